// File: doc/BRIEF.md
# Real-Time Clock Match Counter

This block is a 32-bit up-counter that keeps calendar-style time for a larger timer. A slow tick-enable input, one clock wide and normally produced once per second outside the block, advances the count. When the clock mode is switched on, the count is loaded with 1. From then on it rises by one on every tick. When the count equals a programmable compare value, the next tick does not add one. It returns the count to 0, and counting goes on from there.

Each compare hit latches a raw status flag. A masked copy of that flag is driven out, and so is an interrupt line. Both follow the raw flag while the interrupt enable is high. Software clears the flag with a write-one-to-clear strobe. If a hit and a clear fall in the same cycle, the hit wins. A debug-stall request has no effect while the clock mode is on, even when stalling is allowed. The real-time count never freezes.

Top module: `rtc_match_counter`

## Requirements
- R1: After reset, `count` is 0x00000001 and `raw_stat`, `masked_stat` and `irq` are 0.
- R2: In the cycle after `enable` goes from 0 to 1, `count` is 0x00000001. A `tick` in that first enabled cycle is ignored.
- R3: While enabled, and after the start cycle, each cycle with `tick`=1 and `count` not equal to `match_val` makes `count` rise by exactly one in the next cycle.
- R4: `count` holds its value in any cycle where `tick`=0, and in any cycle where `enable`=0.
- R5: A cycle that is enabled, past the start cycle, has `tick`=1 and has `count` equal to `match_val` sets `count` to 0x00000000 and `raw_stat` to 1 in the next cycle.
- R6: `clear`=1 in a cycle without a compare hit makes `raw_stat` 0 in the next cycle. Otherwise `raw_stat` stays set until cleared.
- R7: If a compare hit and `clear` occur in the same cycle, `raw_stat` is 1 in the next cycle.
- R8: `masked_stat` and `irq` are both equal to `raw_stat` AND `int_en` in every cycle, combinationally.
- R9: While enabled, `dbg_stall`=1 together with `stall_en`=1 does not stop counting, wrapping or status setting.
- R10: Taking `enable` low and then high again restarts the count at 0x00000001, whatever value it held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Clock mode enable; a 0-to-1 change loads 1 |
| tick | input | 1 | Single-cycle count advance strobe |
| match_val | input | 32 | Compare value at which the count wraps to 0 |
| int_en | input | 1 | Interrupt enable for the compare status |
| clear | input | 1 | Write-one-to-clear strobe for the status |
| dbg_stall | input | 1 | Debug halt request |
| stall_en | input | 1 | Allows the debug halt to freeze the timer |
| count | output | 32 | Current count value |
| raw_stat | output | 1 | Raw compare status |
| masked_stat | output | 1 | Status gated by the interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The in-module properties check the cycle-level rules on every cycle: the load of 1 on start, the increment by one, the hold without a tick, the wrap to 0 with the status set on a hit, clearing, set-over-clear priority, and the stall being ignored. Only the bench scenarios show the longer behaviour, compared against a behavioural model on every clock. That covers repeated wrap periods for small compare values, including a compare value of 1. It also covers the interrupt outputs following the enable as it toggles, and a restart after the counter has been disabled in the middle of a period.

// File: rtl/rtc_match_counter.sv
module rtc_match_counter #(
  parameter int W = 32,
  parameter logic [W-1:0] START = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         enable,
  input  logic         tick,
  input  logic [W-1:0] match_val,
  input  logic         int_en,
  input  logic         clear,
  input  logic         dbg_stall,
  input  logic         stall_en,
  output logic [W-1:0] count,
  output logic         raw_stat,
  output logic         masked_stat,
  output logic         irq
);

  logic en_q;
  logic start, run, hit, frozen;

  // stall freezes only outside clock mode, where nothing counts anyway
  assign frozen = stall_en && dbg_stall && !enable;
  assign start  = enable && !en_q;
  assign run    = enable && en_q && tick && !frozen;
  assign hit    = run && (count == match_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      count    <= START;
      raw_stat <= 1'b0;
    end else begin
      en_q <= enable;
      if (start)
        count <= START;
      else if (hit)
        count <= '0;
      else if (run)
        count <= count + 1'b1;
      if (hit)
        raw_stat <= 1'b1;
      else if (clear)
        raw_stat <= 1'b0;
    end
  end

  assign masked_stat = raw_stat & int_en;
  assign irq         = masked_stat;

  a_r2_start_loads_one: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !en_q) |=> (count == START));

  a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_q && tick && count != match_val) |=> (count == $past(count) + 1'b1));

  a_r4_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && enable && !tick) |=> $stable(count));

  a_r4_hold_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable) |=> $stable(count));

  a_r5_wrap_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && en_q && tick && count == match_val) |=> (count == '0 && raw_stat));

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && !(enable && en_q && tick && count == match_val)) |=> !raw_stat);

  a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (clear && enable && en_q && tick && count == match_val) |=> raw_stat);

  a_r9_stall_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_en && dbg_stall && enable && en_q && tick && count != match_val)
      |=> (count == $past(count) + 1'b1));

endmodule

// File: tb/tb_rtc_match_counter.sv
module tb_rtc_match_counter;
  logic clk = 0;
  logic rst_n = 0;
  logic enable = 0, tick = 0, int_en = 0, clear = 0, dbg_stall = 0, stall_en = 0;
  logic [31:0] match_val = 32'd5;
  logic [31:0] count;
  logic raw_stat, masked_stat, irq;

  int checks = 0;
  int failures = 0;
  string tag = "R1";

  longint m_cnt = 1;
  bit m_raw = 0, m_enq = 0;

  always #5 clk = ~clk;

  rtc_match_counter dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .match_val(match_val),
    .int_en(int_en), .clear(clear), .dbg_stall(dbg_stall), .stall_en(stall_en),
    .count(count), .raw_stat(raw_stat), .masked_stat(masked_stat), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 1; m_raw <= 0; m_enq <= 0;
    end else begin
      bit h;
      h = enable && m_enq && tick && (m_cnt == longint'(match_val));
      m_enq <= enable;
      if (enable && !m_enq) m_cnt <= 1;
      else if (h) m_cnt <= 0;
      else if (enable && tick) m_cnt <= (m_cnt + 1) % 64'h1_0000_0000;
      if (h) m_raw <= 1;
      else if (clear) m_raw <= 0;
    end
  end

  task automatic check(string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("count", count, m_cnt);
    check("raw_stat", raw_stat, m_raw);
    check("masked_stat R8", masked_stat, m_raw & int_en);
    check("irq R8", irq, m_raw & int_en);
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n, int gap);
    for (int i = 0; i < n; i++) begin
      tick = 1; cyc(1); tick = 0; cyc(gap);
    end
  endtask

  initial begin
    cyc(3);
    tag = "R1";
    check("reset count", count, 1);
    check("reset raw", raw_stat, 0);
    check("reset irq", irq, 0);
    rst_n = 1; cyc(1);

    tag = "R4 disabled"; ticks(3, 1);
    tag = "R2"; enable = 1; tick = 1; cyc(1); tick = 0; cyc(1);
    check("start count", count, 1);
    tag = "R3"; ticks(2, 0);
    tag = "R4 gaps"; ticks(1, 3);
    tag = "R5"; int_en = 0; ticks(12, 1);
    tag = "R8"; int_en = 1; cyc(2); int_en = 0; cyc(1); int_en = 1;
    tag = "R6"; clear = 1; cyc(1); clear = 0; cyc(1);
    check("cleared", raw_stat, 0);
    tag = "R7";
    while (count != match_val) ticks(1, 0);
    tick = 1; clear = 1; cyc(1); tick = 0; clear = 0;
    check("set wins", raw_stat, 1);
    tag = "R9"; stall_en = 1; dbg_stall = 1; ticks(14, 1);
    stall_en = 0; dbg_stall = 0;
    tag = "R5 match1"; match_val = 32'd1; clear = 1; cyc(1); clear = 0;
    enable = 0; cyc(2); enable = 1; cyc(1); ticks(6, 0);
    tag = "R10"; match_val = 32'd100; ticks(5, 0);
    enable = 0; ticks(2, 0); enable = 1; cyc(1);
    check("restart", count, 1);
    ticks(4, 2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule